// File: doc/BRIEF.md
# ECC Error Capture Register

This block is one 32-bit error-logging register of a memory controller. An ECC checker elsewhere in the controller reports each checked read with a strobe and two flags: one for a corrected single-bit error and one for an uncorrectable multi-bit error. With the strobe come the 32-bit access address and the 8-bit syndrome. The register records the type, upper address bits and syndrome of the first error only. That record stays frozen until software re-arms capture by writing ones to both status bits in the same write.

Besides the log, the register holds three control bits. One turns off the scrub request that each corrected read normally raises. The other two gate the status flags onto a non-maskable-interrupt request and a system-error request. Software reads and writes the register as a whole 32-bit word. The bus that carries those accesses, the ECC logic and the scrub write itself are outside this block.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous active-high reset every register bit reads 0, and `scrub_req`, `nmi_req` and `serr_req` are 0.
- R2: Bit 31 (scrub off), bit 3 (system-error enable) and bit 2 (NMI enable) take the written value on every write and read back unchanged.
- R3: Bits 30:12 hold bits 31:13 of the logged address and bits 11:4 hold the logged syndrome. Writes never change these fields.
- R4: Bit 1 marks a logged multi-bit error and bit 0 a logged single-bit error. An event that carries both flags is logged as multi-bit.
- R5: A write with bits 1:0 equal to 11 clears both status bits and re-arms capture. A write with bits 1:0 equal to 00, 01 or 10 leaves the status bits, address and syndrome unchanged.
- R6: While either status bit is set, later error events change neither status bit, the address or the syndrome.
- R7: When a re-arming write and an error event fall in the same cycle, the clear applies first and the new event is logged.
- R8: `nmi_req` equals bit 0 AND bit 2, and `serr_req` equals bit 1 AND bit 3, at all times.
- R9: In the cycle after a strobed single-bit event that has no multi-bit flag, `scrub_req` is 1 for exactly one cycle, provided bit 31 read 0 before that edge. This holds whether or not the log is frozen. No other event raises it.
- R10: The error flags have no effect when the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_valid | input | 1 | Strobe: one checked read this cycle |
| chk_single | input | 1 | Corrected single-bit error on the read |
| chk_multi | input | 1 | Uncorrectable multi-bit error on the read |
| chk_addr | input | 32 | Address of the checked read |
| chk_syndrome | input | 8 | Syndrome of the checked read |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data |
| scrub_req | output | 1 | One-cycle request to rewrite corrected data |
| nmi_req | output | 1 | Non-maskable-interrupt request level |
| serr_req | output | 1 | System-error request level |

## Verification
The bench sends a second error while the log is frozen, of the same type and of the other type. A design that does not freeze would overwrite the address and syndrome, or set both status bits. It also writes only one status bit, which a design that re-arms too early would take as a clear. It puts a clear and a new error in the same cycle, which a design that applies them in the wrong order would end with an empty log. It checks that a corrected read on a frozen log still raises a scrub pulse, that a read with both error flags raises none, and that error flags with the strobe low change nothing.

// File: rtl/eccl_pkg.sv
package eccl_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 32;
    localparam int SYN_W     = 8;
    localparam int ADDR_HI_W = 19;
    localparam int ADDR_LSB  = ADDR_W - ADDR_HI_W;

    localparam int POS_SCRUB_OFF = 31;
    localparam int POS_ADDR      = 12;
    localparam int POS_SYN       = 4;
    localparam int POS_SERR_EN   = 3;
    localparam int POS_NMI_EN    = 2;
    localparam int POS_MBE       = 1;
    localparam int POS_SBE       = 0;

    typedef struct packed {
        logic scrub_off;
        logic serr_en;
        logic nmi_en;
    } ctrl_t;

    typedef struct packed {
        logic mbe;
        logic sbe;
    } flags_t;

    typedef struct packed {
        flags_t                 flags;
        logic [ADDR_HI_W-1:0]   addr_hi;
        logic [SYN_W-1:0]       syn;
    } log_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_SINGLE = 2'd1,
        EV_MULTI  = 2'd2
    } ev_kind_e;

    // Multi-bit outranks single-bit; nothing counts without the strobe.
    function automatic ev_kind_e classify(input logic stb, input logic s, input logic m);
        if (!stb)   return EV_NONE;
        else if (m) return EV_MULTI;
        else if (s) return EV_SINGLE;
        else        return EV_NONE;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input ctrl_t c, input log_t l);
        logic [REG_W-1:0] r;
        r = '0;
        r[POS_SCRUB_OFF]                     = c.scrub_off;
        r[POS_ADDR +: ADDR_HI_W]             = l.addr_hi;
        r[POS_SYN +: SYN_W]                  = l.syn;
        r[POS_SERR_EN]                       = c.serr_en;
        r[POS_NMI_EN]                        = c.nmi_en;
        r[POS_MBE]                           = l.flags.mbe;
        r[POS_SBE]                           = l.flags.sbe;
        return r;
    endfunction

endpackage

// File: rtl/eccl_ctrl.sv
module eccl_ctrl
    import eccl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic             rearm
);

    logic unused_wbits;
    assign unused_wbits = ^{wdata[POS_SCRUB_OFF-1:POS_SYN]};

    // Re-arm needs both status bits written with 1 in one access.
    assign rearm = wr && wdata[POS_MBE] && wdata[POS_SBE];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr) begin
            ctrl_q.scrub_off <= wdata[POS_SCRUB_OFF];
            ctrl_q.serr_en   <= wdata[POS_SERR_EN];
            ctrl_q.nmi_en    <= wdata[POS_NMI_EN];
        end
    end

    a_r2_ctrl_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctrl_q.scrub_off == $past(wdata[POS_SCRUB_OFF])
             && ctrl_q.serr_en   == $past(wdata[POS_SERR_EN])
             && ctrl_q.nmi_en    == $past(wdata[POS_NMI_EN])));

endmodule

// File: rtl/eccl_capture.sv
module eccl_capture
    import eccl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ev_kind_e             ev,
    input  logic [ADDR_HI_W-1:0] ev_addr_hi,
    input  logic [SYN_W-1:0]     ev_syn,
    input  logic                 rearm,
    output log_t                 log_q
);

    logic frozen_eff;
    log_t log_d;

    // A same-cycle re-arm is applied before the event is considered.
    assign frozen_eff = (log_q.flags.mbe || log_q.flags.sbe) && !rearm;

    always_comb begin
        log_d = log_q;
        if (rearm) begin
            log_d.flags = '0;
        end
        if (!frozen_eff && ev != EV_NONE) begin
            log_d.flags.mbe = (ev == EV_MULTI);
            log_d.flags.sbe = (ev == EV_SINGLE);
            log_d.addr_hi   = ev_addr_hi;
            log_d.syn       = ev_syn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) log_q <= '0;
        else     log_q <= log_d;
    end

    a_r4_one_flag: assert property (@(posedge clk) disable iff (rst)
        $onehot0({log_q.flags.mbe, log_q.flags.sbe}));

    a_r6_frozen_log: assert property (@(posedge clk) disable iff (rst)
        ((log_q.flags.mbe || log_q.flags.sbe) && !rearm) |=> $stable(log_q));

    a_r5_rearm_clears: assert property (@(posedge clk) disable iff (rst)
        (rearm && ev == EV_NONE) |=> (log_q.flags == '0));

    a_r10_flag_needs_event: assert property (@(posedge clk) disable iff (rst)
        $rose(log_q.flags.mbe || log_q.flags.sbe) |-> $past(ev != EV_NONE));

endmodule

// File: rtl/eccl_signal.sv
module eccl_signal
    import eccl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ev_kind_e ev,
    input  ctrl_t    ctrl_q,
    input  flags_t   flags_q,
    output logic     scrub_req,
    output logic     nmi_req,
    output logic     serr_req
);

    always_ff @(posedge clk) begin
        if (rst) scrub_req <= 1'b0;
        else     scrub_req <= (ev == EV_SINGLE) && !ctrl_q.scrub_off;
    end

    assign nmi_req  = flags_q.sbe && ctrl_q.nmi_en;
    assign serr_req = flags_q.mbe && ctrl_q.serr_en;

    a_r9_scrub_cause: assert property (@(posedge clk) disable iff (rst)
        scrub_req |-> $past(ev == EV_SINGLE && !ctrl_q.scrub_off));

    a_r9_scrub_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.scrub_off || ev != EV_SINGLE) |=> !scrub_req);

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import eccl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chk_valid,
    input  logic                 chk_single,
    input  logic                 chk_multi,
    input  logic [ADDR_W-1:0]    chk_addr,
    input  logic [SYN_W-1:0]     chk_syndrome,
    input  logic                 csr_wr,
    input  logic [REG_W-1:0]     csr_wdata,
    output logic [REG_W-1:0]     csr_rdata,
    output logic                 scrub_req,
    output logic                 nmi_req,
    output logic                 serr_req
);

    ev_kind_e ev;
    ctrl_t    ctrl_q;
    log_t     log_q;
    logic     rearm;
    logic     unused_addr_lo;

    assign unused_addr_lo = ^{chk_addr[ADDR_LSB-1:0]};
    assign ev = classify(chk_valid, chk_single, chk_multi);

    eccl_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr     (csr_wr),
        .wdata  (csr_wdata),
        .ctrl_q (ctrl_q),
        .rearm  (rearm)
    );

    eccl_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .ev_addr_hi (chk_addr[ADDR_W-1:ADDR_LSB]),
        .ev_syn     (chk_syndrome),
        .rearm      (rearm),
        .log_q      (log_q)
    );

    eccl_signal u_sig (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .ctrl_q    (ctrl_q),
        .flags_q   (log_q.flags),
        .scrub_req (scrub_req),
        .nmi_req   (nmi_req),
        .serr_req  (serr_req)
    );

    assign csr_rdata = pack_reg(ctrl_q, log_q);

    a_r8_nmi_level: assert property (@(posedge clk) disable iff (rst)
        nmi_req == (csr_rdata[POS_SBE] && csr_rdata[POS_NMI_EN]));

    a_r8_serr_level: assert property (@(posedge clk) disable iff (rst)
        serr_req == (csr_rdata[POS_MBE] && csr_rdata[POS_SERR_EN]));

    a_r1_reset_clean: assert property (@(posedge clk)
        $past(rst) |-> (csr_rdata == '0 && !scrub_req));

endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_valid = 1'b0, chk_single = 1'b0, chk_multi = 1'b0;
    logic [31:0] chk_addr = '0;
    logic [7:0]  chk_syndrome = '0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        scrub_req, nmi_req, serr_req;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ecc_err_log u0 (
        .clk(clk), .rst(rst),
        .chk_valid(chk_valid), .chk_single(chk_single), .chk_multi(chk_multi),
        .chk_addr(chk_addr), .chk_syndrome(chk_syndrome),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .scrub_req(scrub_req), .nmi_req(nmi_req), .serr_req(serr_req)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic        stb;
        logic        s;
        logic        m;
        logic [31:0] addr;
        logic [7:0]  syn;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000000C, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 32'hABCDE123, 8'h5A},
        '{1'b0, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b1, 32'h12345678, 8'hC3},
        '{1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 32'h0F0F0000, 8'h01},
        '{1'b1, 32'h7FFFFFF0, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b1, 32'h0000000D, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b1, 32'h0000000E, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b1, 32'h0000000F, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b0, 32'h00000000, 1'b1, 1'b0, 1'b1, 32'hFFFFE000, 8'h81},
        '{1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 32'h00000000, 8'h22},
        '{1'b1, 32'h8000000F, 1'b1, 1'b1, 1'b0, 32'h00002000, 8'h3C},
        '{1'b1, 32'h8000000F, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 32'h80000000, 8'h44},
        '{1'b1, 32'h00000003, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b0, 32'h00000000, 1'b1, 1'b1, 1'b1, 32'h55555555, 8'h99},
        '{1'b1, 32'h00000003, 1'b0, 1'b0, 1'b0, 32'h00000000, 8'h00},
        '{1'b0, 32'h00000000, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 8'hEE}
    };

    string tags [NV] = '{
        "R2", "R4", "R9", "R6", "R9", "R3", "R5", "R5", "R5",
        "R8", "R6", "R7", "R5", "R9", "R2", "R4", "R5", "R10"
    };

    // Reference state built from the requirement text.
    logic        e_off, e_serr, e_nmi, e_mbe, e_sbe, e_scrub;
    logic [18:0] e_addr;
    logic [7:0]  e_syn;

    function automatic logic [31:0] exp_word();
        return {e_off, e_addr, e_syn, e_serr, e_nmi, e_mbe, e_sbe};
    endfunction

    task automatic model_reset();
        e_off = 0; e_serr = 0; e_nmi = 0; e_mbe = 0; e_sbe = 0;
        e_scrub = 0; e_addr = '0; e_syn = '0;
    endtask

    task automatic model_step(input vec_t v);
        logic old_off;
        old_off = e_off;
        e_scrub = v.stb && v.s && !v.m && !old_off;
        if (v.wr) begin
            e_off = v.wd[31]; e_serr = v.wd[3]; e_nmi = v.wd[2];
            if (v.wd[1] && v.wd[0]) begin e_mbe = 0; e_sbe = 0; end
        end
        if (v.stb && (v.s || v.m) && !e_mbe && !e_sbe) begin
            e_mbe = v.m; e_sbe = !v.m;
            e_addr = v.addr[31:13]; e_syn = v.syn;
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "rdata", csr_rdata, exp_word());
        check(tag, "scrub", {31'd0, scrub_req}, {31'd0, e_scrub});
        check(tag, "nmi",   {31'd0, nmi_req},   {31'd0, e_sbe && e_nmi});
        check(tag, "serr",  {31'd0, serr_req},  {31'd0, e_mbe && e_serr});
    endtask

    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        csr_wr = v.wr; csr_wdata = v.wd;
        chk_valid = v.stb; chk_single = v.s; chk_multi = v.m;
        chk_addr = v.addr; chk_syndrome = v.syn;
        @(posedge clk);
        model_step(v);
        @(negedge clk);
        csr_wr = 0; chk_valid = 0; chk_single = 0; chk_multi = 0;
        check_all(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 0;
        for (int i = 0; i < NV; i++) apply(VECS[i], tags[i]);

        // Directed: one-cycle scrub pulse ends on an idle cycle (R9).
        apply('{1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 32'h00004000, 8'h10}, "R9");
        apply('{1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 8'h0}, "R9");

        // Directed: reset in mid-run returns everything to zero (R1).
        apply('{1'b1, 32'h8000000C, 1'b1, 1'b0, 1'b1, 32'hDEADBEEF, 8'h77}, "R8");
        @(negedge clk); rst = 1;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 0;
        check_all("R1");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule